// File: doc/BRIEF.md
# Strobe-Handshake Register Bus Slave

This block sits on the peripheral side of an asynchronous host bus of the strobe-and-acknowledge kind. The host marks an address phase with an active-low address strobe, then performs one or more data phases with an active-low data strobe and a read/write level. The block brings every strobe into the system clock domain through two-flop synchronisers. It captures the 9-bit address when the address strobe deasserts. It then reads or writes a small internal register file and answers each data phase with an active-low acknowledge, using a full four-phase handshake.

After one address phase the host may issue any number of data phases. The internal address steps up by one after every completed data phase, so a run of sequential registers needs only one address phase. A static width-select input chooses between a 16-bit data path and an 8-bit one. In 8-bit mode only byte lane 0 takes part. The data bus is presented as separate input, output and per-bit output-enable vectors for the pad ring.

Top module: `hostbus_regs_slave`

## Requirements
- R1: While reset is held and after it is released with no strobe activity, `ack_n` is high and `data_oe` is all zero.
- R2: The value on `addr` is captured as the current register address when `as_n` returns high.
- R3: A data phase with `rw` low writes `data_i` into the register at the current address and is acknowledged.
- R4: A data phase with `rw` high returns the register's contents on `data_o`. `data_oe` is nonzero only while `ds_n` is low, `rw` is high and the read has been acknowledged. It falls to zero in the same cycle that `ds_n` rises.
- R5: `ack_n` goes low only after `ds_n` is seen low. It stays low until `ds_n` has been seen high through the synchroniser, and then returns high.
- R6: Each completed data phase increments the current address by one, without a new address phase. Address 511 is followed by 0.
- R7: With `wide_sel` low, only bits 7:0 are driven on reads (`data_oe` = 0x00FF). Writes change only bits 7:0 of the register, and bits 15:8 of `data_i` are ignored.
- R8: With `wide_sel` high, all 16 bits are driven on reads (`data_oe` = 0xFFFF) and written on writes.
- R9: Addresses 64 to 511 (at or above the default depth of 64) read as zero, ignore writes and do not alias onto implemented registers, yet are still acknowledged.
- R10: When an address capture and the completion of a data phase fall in the same clock cycle, the captured address wins over the increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_sel | input | 1 | Static data path width: 1 selects 16 bits, 0 selects 8 bits |
| as_n | input | 1 | Active-low address strobe from the host |
| ds_n | input | 1 | Active-low data strobe from the host |
| rw | input | 1 | High for read, low for write |
| addr | input | 9 | Host register address |
| data_i | input | 16 | Data bus as seen at the pad input |
| data_o | output | 16 | Read data towards the pad output |
| data_oe | output | 16 | Per-bit output enable for the data pads |
| ack_n | output | 1 | Active-low transfer acknowledge |

## Verification
Two functions can coincide in one cycle: loading a new address when `as_n` rises, and stepping the address when a data phase completes. The bench provokes this by lowering `as_n` with a new address while a read is acknowledged. It then raises `as_n` and `ds_n` on the same clock, so both synchronised edges reach the address unit together. The next data phase, issued without a further address phase, must return the register at the newly captured address rather than the incremented one. The checker also states the load-over-step priority as a property.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RDWAIT = 2'd1,
    ST_ACK    = 2'd2
  } hb_state_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end
endmodule

// File: rtl/hb_addr_unit.sv
module hb_addr_unit #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr
);
  always_ff @(posedge clk) begin
    if (rst)       cur_addr <= '0;
    else if (load) cur_addr <= load_val;
    else if (step) cur_addr <= cur_addr + 1'b1;
  end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
  parameter int DEPTH = 64,
  parameter int LANES = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int DW = LANES * 8
) (
  input  logic             clk,
  input  logic [LANES-1:0] we_lane,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [0:DEPTH-1];
    logic [7:0] rbyte;
    always_ff @(posedge clk) begin
      if (we_lane[g]) mem[waddr] <= wdata[g*8 +: 8];
      rbyte <= mem[raddr];
    end
    assign rdata[g*8 +: 8] = rbyte;
  end
endmodule

// File: rtl/hostbus_regs_slave.sv
module hostbus_regs_slave #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_sel,
  input  logic              as_n,
  input  logic              ds_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data_oe,
  output logic              ack_n
);
  import hb_pkg::*;

  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W:0] DEPTH_L = (ADDR_W+1)'(DEPTH);

  // synchronised strobes: {as, ds, rw}
  logic [2:0] strobes_s;
  logic       as_s, ds_s, rw_s;

  hb_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({as_n, ds_n, rw}),
    .dout(strobes_s)
  );
  assign {as_s, ds_s, rw_s} = strobes_s;

  logic as_prev;
  logic as_rise;
  always_ff @(posedge clk) begin
    if (rst) as_prev <= 1'b1;
    else     as_prev <= as_s;
  end
  assign as_rise = as_s & ~as_prev;

  hb_state_t         state;
  logic              step;
  logic [ADDR_W-1:0] cur_addr;

  assign step = (state == ST_ACK) && ds_s;

  hb_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .load    (as_rise),
    .load_val(addr),
    .step    (step),
    .cur_addr(cur_addr)
  );

  logic hit;
  assign hit = ({1'b0, cur_addr} < DEPTH_L);

  // active lanes and per-bit mask
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] bit_mask;
  always_comb begin
    lane_en    = {LANES{wide_sel}};
    lane_en[0] = 1'b1;
    for (int b = 0; b < DATA_W; b++) bit_mask[b] = lane_en[b/8];
  end

  logic              wr_go;
  logic [LANES-1:0]  we_lane;
  logic [DATA_W-1:0] rdata;
  assign wr_go   = (state == ST_IDLE) && !ds_s && !rw_s && hit;
  assign we_lane = wr_go ? lane_en : '0;

  hb_regfile #(.DEPTH(DEPTH), .LANES(LANES)) u_rf (
    .clk    (clk),
    .we_lane(we_lane),
    .waddr  (cur_addr[IDX_W-1:0]),
    .wdata  (data_i),
    .raddr  (cur_addr[IDX_W-1:0]),
    .rdata  (rdata)
  );

  logic              rd_hit_q;
  logic              oe_q;
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_n    <= 1'b1;
      oe_q     <= 1'b0;
      rd_hit_q <= 1'b0;
      dout_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!ds_s) begin
            rd_hit_q <= hit;
            if (rw_s) begin
              state <= ST_RDWAIT;
            end else begin
              ack_n <= 1'b0;
              state <= ST_ACK;
            end
          end
        end
        ST_RDWAIT: begin
          dout_q <= rd_hit_q ? (rdata & bit_mask) : '0;
          oe_q   <= 1'b1;
          ack_n  <= 1'b0;
          state  <= ST_ACK;
        end
        ST_ACK: begin
          if (ds_s) begin
            ack_n <= 1'b1;
            oe_q  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign data_o  = dout_q;
  assign data_oe = (oe_q && !ds_n && rw) ? bit_mask : '0;
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_sel,
  input logic              ds_s,
  input logic              ack_n,
  input logic [DATA_W-1:0] data_oe,
  input logic              as_rise,
  input logic              step,
  input logic [ADDR_W-1:0] addr,
  input logic [ADDR_W-1:0] cur_addr
);
  // R4: pads driven only during an acknowledged read
  assert_oe_needs_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (data_oe != '0) |-> !ack_n);

  // R5: acknowledge released only once the data strobe is seen high
  assert_ack_release_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_n) |-> $past(ds_s));

  // R5: acknowledge asserted only while the data strobe is seen low
  assert_ack_assert_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> !$past(ds_s));

  // R7: upper lanes stay undriven in narrow mode
  assert_narrow_lanes_R7: assert property (@(posedge clk) disable iff (rst)
    !wide_sel |-> (data_oe[DATA_W-1:8] == '0));

  // R6: completed phase steps the address with wrap
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !as_rise) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

  // R2 / R10: capture takes the host address, winning over a step
  assert_addr_load_R10: assert property (@(posedge clk) disable iff (rst)
    as_rise |=> (cur_addr == $past(addr)));
endmodule

bind hostbus_regs_slave hb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wide_sel(wide_sel),
  .ds_s    (ds_s),
  .ack_n   (ack_n),
  .data_oe (data_oe),
  .as_rise (as_rise),
  .step    (step),
  .addr    (addr),
  .cur_addr(cur_addr)
);

// File: tb/sim_hostbus_regs_slave.sv
`timescale 1ns/1ps
module sim_hostbus_regs_slave;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wide_sel = 1'b1;
  logic        as_n = 1'b1;
  logic        ds_n = 1'b1;
  logic        rw = 1'b1;
  logic [8:0]  addr = '0;
  logic [15:0] data_i = '0;
  logic [15:0] data_o, data_oe;
  logic        ack_n;

  always #2 clk = ~clk;

  hostbus_regs_slave u0 (
    .clk(clk), .rst(rst), .wide_sel(wide_sel), .as_n(as_n), .ds_n(ds_n),
    .rw(rw), .addr(addr), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .ack_n(ack_n)
  );

  typedef struct {
    logic [15:0] data;
    logic [15:0] mask;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] model [0:63];
  logic [8:0]  b_addr = '0;
  int          cyc = 0;
  logic        ack_prev = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      finish_run();
    end
  end

  // monitor: pop expected read data when acknowledge falls on a read
  always @(negedge clk) begin
    if (!rst && ack_prev && !ack_n && rw) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R4 unexpected read ack", data_o, 16'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk((data_o & e.mask) == e.data, {e.tag, " data"}, data_o & e.mask, e.data);
        chk(data_oe == e.mask, {e.tag, " oe lanes"}, data_oe, e.mask);
      end
    end
    ack_prev = ack_n;
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_addr(input logic [8:0] a);
    @(negedge clk);
    as_n = 1'b0; addr = a;
    cycles(2);
    as_n = 1'b1;
    cycles(5);
    b_addr = a;
  endtask

  task automatic wait_ack(input logic lvl, input string tag);
    int n = 0;
    while (ack_n !== lvl && n < 20) begin @(negedge clk); n++; end
    chk(ack_n === lvl, tag, {15'b0, ack_n}, {15'b0, lvl});
  endtask

  task automatic expect_read(input string tag);
    exp_t e;
    e.mask = wide_sel ? 16'hFFFF : 16'h00FF;
    e.data = (b_addr < 64) ? (model[b_addr[5:0]] & e.mask) : 16'h0;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  task automatic access(input bit rd, input logic [15:0] wd, input string tag);
    @(negedge clk);
    rw = rd; data_i = wd;
    @(negedge clk);
    if (rd) expect_read(tag);
    ds_n = 1'b0;
    wait_ack(1'b0, {tag, " ack"});
    cycles(1);
    ds_n = 1'b1;
    #0.5;
    chk(data_oe == 16'h0, "R4 release on ds_n high", data_oe, 16'h0);
    chk(ack_n == 1'b0, "R5 ack held until ds seen", {15'b0, ack_n}, 16'h0);
    wait_ack(1'b1, "R5 ack release");
    if (!rd && b_addr < 64) begin
      if (wide_sel) model[b_addr[5:0]] = wd;
      else model[b_addr[5:0]][7:0] = wd[7:0];
    end
    b_addr = b_addr + 1'b1;
    cycles(1);
    rw = 1'b1;
  endtask

  initial begin
    cycles(5);
    chk(ack_n == 1'b1, "R1 ack idle in reset", {15'b0, ack_n}, 16'h1);
    chk(data_oe == 16'h0, "R1 oe idle in reset", data_oe, 16'h0);
    rst = 1'b0;
    cycles(4);
    chk(ack_n == 1'b1 && data_oe == 16'h0, "R1 idle after reset", data_oe, 16'h0);

    // R2 R3 R6 R8: 16-bit burst writes and reads
    wide_sel = 1'b1;
    set_addr(9'd10);
    access(0, 16'h1234, "R3 write");
    access(0, 16'hABCD, "R6 burst write");
    set_addr(9'd10);
    access(1, 0, "R2 R8 read");
    access(1, 0, "R6 burst read");

    // R7: narrow mode writes only the low byte
    wide_sel = 1'b0;
    set_addr(9'd10);
    access(0, 16'hFF77, "R7 narrow write");
    set_addr(9'd10);
    access(1, 0, "R7 narrow read");
    wide_sel = 1'b1;
    set_addr(9'd10);
    access(1, 0, "R7 upper byte kept");

    // R9: unimplemented address
    set_addr(9'd36);
    access(0, 16'h5555, "R9 setup");
    set_addr(9'd100);
    access(0, 16'hBEEF, "R9 write ignored");
    set_addr(9'd100);
    access(1, 0, "R9 reads zero");
    set_addr(9'd36);
    access(1, 0, "R9 no alias");

    // R6: wrap 511 -> 0
    set_addr(9'd0);
    access(0, 16'h0F0F, "R6 setup");
    set_addr(9'd511);
    access(1, 0, "R6 top reads zero");
    access(1, 0, "R6 wrap to zero");

    // R10: capture and step in the same cycle
    set_addr(9'd40);
    access(0, 16'h4040, "R10 setup");
    access(0, 16'h4141, "R10 setup");
    set_addr(9'd60);
    access(0, 16'h6060, "R10 setup");
    set_addr(9'd40);
    @(negedge clk); rw = 1'b1;
    @(negedge clk);
    expect_read("R10 first read");
    ds_n = 1'b0;
    wait_ack(1'b0, "R10 ack");
    as_n = 1'b0; addr = 9'd60;
    cycles(2);
    as_n = 1'b1; ds_n = 1'b1;
    wait_ack(1'b1, "R10 ack release");
    cycles(4);
    b_addr = 9'd60;
    access(1, 0, "R10 capture wins");

    cycles(5);
    chk(sb_q.size() == 0, "R4 all reads seen", 16'(sb_q.size()), 16'h0);
    finish_run();
  end
endmodule